// File: doc/BRIEF.md
# Dual-Mode Serial Control Port

This block is a slave port that gives an external controller read and write access to a bank of internal registers over a few serial wires. A static mode input picks one of two framings. Mode 0 is SPI-style and is framed by an active-low chip select. Mode 1 is a DSP serial-port style, with a receive frame sync that opens each incoming word and a transmit frame sync that opens the outgoing read word. In both modes the chip select must be low for the port to respond. Serial input is taken on falling SCLK edges. Serial output is launched on rising SCLK edges.

All serial inputs pass through a two-flop synchronizer into the core clock, and SCLK edges are found from the synchronized samples. SCLK must therefore run well below the core clock. A transfer is a 16-bit instruction word followed by a 16-bit data word, both sent MSB first. In the instruction word, bit 15 is the read flag (1 = read), bits 14:8 are don't-care and bits 7:0 are the register address. The register bank sits behind a plain parallel interface: address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data that the port captures one core cycle after the read strobe. The mode input may change only while the chip select is high. SDO comes with a separate enable, so the pad can be tri-stated outside read data.

Top module: `serial_ctrl_port`

## Requirements
- R1: With mode_i = 0 and cs_ni low, SDI bits are taken on falling SCLK edges, MSB first. An instruction with bit 15 = 0 is followed by a 16-bit data word. After that word's 16th bit, reg_we_o pulses for one cycle with reg_addr_o equal to instruction bits 7:0 and reg_wdata_o equal to the data word. Instruction bits 14:8 have no effect.
- R2: An instruction with bit 15 = 1 gives exactly one one-cycle reg_re_o pulse with reg_addr_o equal to bits 7:0. reg_rdata_i is captured one core cycle after that pulse. The captured word then goes out on sdo_o MSB first, one bit launched per rising SCLK edge. In mode 0, the first rising edge after the instruction's 16th falling edge launches bit 15.
- R3: sdo_oe_o is low out of reset, during instruction words, during write transfers, and once the 16th read data bit has been sampled on its falling edge. It is high while read data bits are on sdo_o.
- R4: If cs_ni rises before a word is complete, the transfer is abandoned: no write occurs and the bit counter clears. The next selection then decodes its first 16 bits as a new instruction.
- R5: With mode_i = 1, a falling SCLK edge that sees the receive frame sync high takes that SDI bit as bit 15 of a new word. Falling edges outside a word are ignored. Instruction and write data words each need their own sync.
- R6: With mode_i = 1, read data stays off SDO until a rising SCLK edge that sees the transmit frame sync high. That edge launches bit 15, and the following rising edges launch the remaining bits.
- R7: In either mode, once cs_ni has been high for 5 core cycles, reg_we_o, reg_re_o and sdo_oe_o stay low, whatever SCLK and the syncs do.
- R8: reg_we_o and reg_re_o are one-cycle pulses. They are never high together, and sdo_oe_o is low whenever either is high.
- R9: Within one selection, a completed instruction and data word pair is followed by a new instruction word, so several accesses can run under one chip-select low period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Framing select: 0 chip-select framing, 1 frame-sync framing |
| sclk_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Active-low chip select |
| rfs_i | input | 1 | Receive frame sync (mode 1) |
| tfs_i | input | 1 | Transmit frame sync (mode 1) |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low = high impedance) |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 16 | Register read data, valid one cycle after reg_re_o |

## Verification
The assertions watch the strobe discipline on every cycle: both strobes are one-cycle pulses, they never overlap, SDO is never enabled during a strobe, and the port stays quiet once the chip select has been high for a few cycles. The bench scenarios are the only check on bit order, address and data decoding, the ignored reserved bits, and the launch alignment of read data. The same holds for the frame-sync waits with idle SCLK gaps, the aborted words and the chained accesses. In those scenarios every write is confirmed by reading the register back, in both framings.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDATA,
    ST_RREQ,
    ST_RWAIT,
    ST_RDATA
  } scp_state_e;

  localparam logic MODE_SPI   = 1'b0;
  localparam logic MODE_SPORT = 1'b1;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/scp_edge.sv
module scp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/scp_rx_ctrl.sv
module scp_rx_ctrl
  import scp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sport_i,
  input  logic          sel_i,
  input  logic          fall_i,
  input  logic          sdi_i,
  input  logic          rfs_i,
  input  logic          tx_done_i,
  output logic          rd_active_o,
  output logic          load_o,
  output logic          re_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int             CW   = $clog2(DW);
  localparam logic [CW-1:0]  LAST = CW'(DW - 1);
  localparam logic [CW-1:0]  ONE  = CW'(1);

  scp_state_e    state_q;
  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q;

  logic          in_rx, restart, take, word_done;
  logic [DW-1:0] nxt_word;

  assign in_rx     = (state_q == ST_CMD) || (state_q == ST_WDATA);
  // a receive sync re-aligns the word in frame-sync mode
  assign restart   = sport_i & rfs_i;
  assign take      = fall_i & in_rx & (restart | ~sport_i | (cnt_q != '0));
  assign word_done = take & ~restart & (cnt_q == LAST);
  assign nxt_word  = {sh_q, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (!sel_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
          end
          ST_CMD, ST_WDATA: begin
            if (take) begin
              sh_q  <= nxt_word[DW-2:0];
              if (restart)           cnt_q <= ONE;
              else if (cnt_q == LAST) cnt_q <= '0;
              else                   cnt_q <= cnt_q + 1'b1;
              if (word_done) begin
                if (state_q == ST_CMD) begin
                  addr_q  <= nxt_word[AW-1:0];
                  state_q <= nxt_word[DW-1] ? ST_RREQ : ST_WDATA;
                end else begin
                  wdata_q <= nxt_word;
                  we_q    <= 1'b1;
                  state_q <= ST_CMD;
                end
              end
            end
          end
          ST_RREQ:  state_q <= ST_RWAIT;
          ST_RWAIT: state_q <= ST_RDATA;
          ST_RDATA: begin
            if (tx_done_i) begin
              state_q <= ST_CMD;
              cnt_q   <= '0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_active_o = (state_q == ST_RDATA);
  assign load_o      = (state_q == ST_RWAIT);
  assign re_o        = (state_q == ST_RREQ);
  assign we_o        = we_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
endmodule

// File: rtl/scp_tx.sv
module scp_tx #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sport_i,
  input  logic          load_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          active_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          tfs_i,
  output logic          sdo_o,
  output logic          oe_o,
  output logic          done_o
);
  localparam int            CW   = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] fcnt_q;
  logic          on_q, sdo_q, launch;

  // first launch waits for the transmit sync in frame-sync mode
  assign launch = rise_i & (on_q | ~sport_i | tfs_i);
  assign done_o = active_i & on_q & fall_i & (fcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      fcnt_q <= '0;
      on_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      if (load_i) sh_q <= ld_data_i;
      if (!active_i) begin
        on_q   <= 1'b0;
        fcnt_q <= '0;
        sdo_q  <= 1'b0;
      end else begin
        if (launch) begin
          sdo_q <= sh_q[DW-1];
          sh_q  <= {sh_q[DW-2:0], 1'b0};
          on_q  <= 1'b1;
        end
        if (fall_i && on_q) begin
          if (fcnt_q == LAST) begin
            on_q   <= 1'b0;
            fcnt_q <= '0;
          end else begin
            fcnt_q <= fcnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = on_q;
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          cs_ni,
  input  logic          rfs_i,
  input  logic          tfs_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int             IN_W   = 5;
  // order: sclk, sdi, cs_n, rfs, tfs
  localparam logic [IN_W-1:0] IN_RST = 5'b00100;

  logic [IN_W-1:0] raw, syn;
  logic sclk_s, sdi_s, cs_s, rfs_s, tfs_s;
  logic rise, fall, sport;
  logic rd_active, load, tx_done;

  assign raw   = {sclk_i, sdi_i, cs_ni, rfs_i, tfs_i};
  assign sport = (mode_i == MODE_SPORT);

  scp_sync #(.W(IN_W), .RST_VAL(IN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {sclk_s, sdi_s, cs_s, rfs_s, tfs_s} = syn;

  scp_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_s),
    .rise_o(rise),
    .fall_o(fall)
  );

  scp_rx_ctrl #(.DW(DW), .AW(AW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sport_i    (sport),
    .sel_i      (~cs_s),
    .fall_i     (fall),
    .sdi_i      (sdi_s),
    .rfs_i      (rfs_s),
    .tx_done_i  (tx_done),
    .rd_active_o(rd_active),
    .load_o     (load),
    .re_o       (reg_re_o),
    .we_o       (reg_we_o),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o)
  );

  scp_tx #(.DW(DW)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sport_i  (sport),
    .load_i   (load),
    .ld_data_i(reg_rdata_i),
    .active_i (rd_active),
    .rise_i   (rise),
    .fall_i   (fall),
    .tfs_i    (tfs_s),
    .sdo_o    (sdo_o),
    .oe_o     (sdo_oe_o),
    .done_o   (tx_done)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic sdo_oe_o
);
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  // R7
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd6 && $past(cs_ni, 1) && $past(cs_ni, 2) && $past(cs_ni, 3) &&
     $past(cs_ni, 4) && $past(cs_ni, 5))
    |-> (!reg_we_o && !reg_re_o && !sdo_oe_o));

  // R8
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R8
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  // R3
  strobe_no_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |-> !sdo_oe_o);
endmodule

bind serial_ctrl_port scp_checker u_scp_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .reg_we_o(reg_we_o),
  .reg_re_o(reg_re_o),
  .sdo_oe_o(sdo_oe_o)
);

// File: tb/serial_ctrl_port_bench.sv
module serial_ctrl_port_bench;
  localparam int H = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, rfs = 1'b0, tfs = 1'b0;
  logic sdo_o, sdo_oe_o, reg_we_o, reg_re_o;
  logic [7:0]  reg_addr_o;
  logic [15:0] reg_wdata_o;
  logic [15:0] reg_rdata;

  int n_chk = 0, n_err = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];

  always #2.5 clk = ~clk;

  serial_ctrl_port u_serial_ctrl_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sclk_i(sclk), .sdi_i(sdi),
    .cs_ni(cs_n), .rfs_i(rfs), .tfs_i(tfs), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o),
    .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [15:0] init_val(input int a);
    return 16'(a * 257) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] instr(input logic rd, input logic [7:0] a);
    return {rd, 7'($urandom), a};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      reg_rdata <= '0;
    end else begin
      if (reg_we_o) begin
        mem[reg_addr_o] <= reg_wdata_o;
        we_cnt <= we_cnt + 1;
      end
      if (reg_re_o) begin
        reg_rdata <= mem[reg_addr_o];
        re_cnt <= re_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck(input logic d, input logic r, input logic t, output logic so, output logic soe);
    sdi = d; rfs = r; tfs = t;
    wait_n(Q);
    sclk = 1'b1;
    wait_n(H);
    so = sdo_o; soe = sdo_oe_o;
    sclk = 1'b0;
    wait_n(H - Q);
  endtask

  task automatic spi_word(input logic [15:0] w, output logic [15:0] rd, output int oe_hi);
    logic so, soe;
    oe_hi = 0;
    for (int i = 15; i >= 0; i--) begin
      sck(w[i], 1'b0, 1'b0, so, soe);
      rd[i] = so;
      if (soe) oe_hi++;
    end
  endtask

  task automatic spi_write(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] dummy; int oe_a, oe_b;
    cs_n = 1'b0; wait_n(H);
    spi_word(instr(1'b0, a), dummy, oe_a);
    spi_word(d, dummy, oe_b);
    wait_n(H);
    chk(oe_a == 0 && oe_b == 0, "R3 write oe", 32'(oe_a + oe_b), 0);
    cs_n = 1'b1; wait_n(2 * H);
    exp_mem[a] = d;
  endtask

  task automatic spi_read(input logic [7:0] a, output logic [15:0] rd);
    logic [15:0] dummy; int oe_a, oe_b, re0;
    re0 = re_cnt;
    cs_n = 1'b0; wait_n(H);
    spi_word(instr(1'b1, a), dummy, oe_a);
    spi_word(16'h0, rd, oe_b);
    wait_n(H);
    chk(oe_a == 0 && oe_b == 16, "R3 read oe phases", 32'(oe_a * 100 + oe_b), 16);
    chk(sdo_oe_o == 1'b0, "R3 oe after data", 32'(sdo_oe_o), 0);
    chk(re_cnt == re0 + 1, "R2 one read strobe", 32'(re_cnt - re0), 1);
    cs_n = 1'b1; wait_n(2 * H);
  endtask

  task automatic sport_in(input logic [15:0] w, input int gap);
    logic so, soe;
    for (int g = 0; g < gap; g++) sck(1'($urandom), 1'b0, 1'b0, so, soe);
    for (int i = 15; i >= 0; i--) sck(w[i], i == 15, 1'b0, so, soe);
  endtask

  task automatic sport_write(input logic [7:0] a, input logic [15:0] d, input int gap);
    cs_n = 1'b0; wait_n(H);
    sport_in(instr(1'b0, a), gap);
    sport_in(d, gap);
    wait_n(H);
    cs_n = 1'b1; wait_n(2 * H);
    exp_mem[a] = d;
  endtask

  task automatic sport_read(input logic [7:0] a, input int gap, output logic [15:0] rd);
    logic so, soe; int oe_gap, oe_dat;
    oe_gap = 0; oe_dat = 0;
    cs_n = 1'b0; wait_n(H);
    sport_in(instr(1'b1, a), gap);
    for (int g = 0; g < gap; g++) begin
      sck(1'($urandom), 1'b0, 1'b0, so, soe);
      if (soe) oe_gap++;
    end
    for (int i = 15; i >= 0; i--) begin
      sck(1'b0, 1'b0, i == 15, so, soe);
      rd[i] = so;
      if (soe) oe_dat++;
    end
    wait_n(H);
    chk(oe_gap == 0 && oe_dat == 16, "R6 oe waits for tfs", 32'(oe_gap * 100 + oe_dat), 16);
    chk(sdo_oe_o == 1'b0, "R3 oe after sport data", 32'(sdo_oe_o), 0);
    cs_n = 1'b1; wait_n(2 * H);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, d;
    logic [7:0] a;
    logic so, soe;
    logic [15:0] dummy;
    int oe_x, w0, seed_val;
    seed_val = int'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk(sdo_oe_o == 0 && reg_we_o == 0 && reg_re_o == 0, "R3 reset state",
        {29'd0, sdo_oe_o, reg_we_o, reg_re_o}, 0);

    // R1 R2 directed corners
    spi_write(8'h00, 16'hFFFF);
    spi_read(8'h00, rd);
    chk(rd == 16'hFFFF, "R1 addr 00 all ones", rd, 16'hFFFF);
    spi_write(8'hFF, 16'h0000);
    spi_read(8'hFF, rd);
    chk(rd == 16'h0000, "R1 addr FF zeros", rd, 16'h0000);
    spi_read(8'h5A, rd);
    chk(rd == exp_mem[8'h5A], "R2 untouched register", rd, exp_mem[8'h5A]);
    spi_write(8'h81, 16'h8001);
    chk(mem[8'h81] == 16'h8001, "R1 write lands in bank", mem[8'h81], 16'h8001);
    spi_read(8'h81, rd);
    chk(rd == 16'h8001, "R2 MSB first order", rd, 16'h8001);

    // R1 R2 random
    for (int k = 0; k < 8; k++) begin
      a = 8'($urandom); d = 16'($urandom);
      spi_write(a, d);
      spi_read(a, rd);
      chk(rd == exp_mem[a], "R1 R2 random readback", rd, exp_mem[a]);
    end

    // R4 abort inside data word
    w0 = we_cnt;
    cs_n = 1'b0; wait_n(H);
    spi_word(instr(1'b0, 8'h33), dummy, oe_x);
    for (int i = 0; i < 8; i++) sck(1'b1, 1'b0, 1'b0, so, soe);
    cs_n = 1'b1; wait_n(3 * H);
    chk(we_cnt == w0, "R4 aborted write count", 32'(we_cnt - w0), 0);
    spi_read(8'h33, rd);
    chk(rd == exp_mem[8'h33], "R4 aborted write register", rd, exp_mem[8'h33]);

    // R4 abort inside instruction, then a clean write
    cs_n = 1'b0; wait_n(H);
    for (int i = 0; i < 10; i++) sck(1'b1, 1'b0, 1'b0, so, soe);
    cs_n = 1'b1; wait_n(3 * H);
    spi_write(8'h44, 16'hBEEF);
    spi_read(8'h44, rd);
    chk(rd == 16'hBEEF, "R4 counter reset after abort", rd, 16'hBEEF);

    // R9 write then read under one selection
    cs_n = 1'b0; wait_n(H);
    spi_word(instr(1'b0, 8'h6C), dummy, oe_x);
    spi_word(16'h1234, dummy, oe_x);
    spi_word(instr(1'b1, 8'h6C), dummy, oe_x);
    spi_word(16'h0, rd, oe_x);
    wait_n(H);
    cs_n = 1'b1; wait_n(2 * H);
    exp_mem[8'h6C] = 16'h1234;
    chk(rd == 16'h1234, "R9 chained access", rd, 16'h1234);
    chk(oe_x == 16, "R9 chained read oe", 32'(oe_x), 16);

    // frame-sync mode
    mode = 1'b1; wait_n(2 * H);
    for (int k = 0; k < 5; k++) begin
      a = 8'($urandom); d = 16'($urandom);
      sport_write(a, d, k + 1);
      chk(mem[a] == d, "R5 sport write with gaps", mem[a], d);
      sport_read(a, 3 - (k % 3), rd);
      chk(rd == d, "R6 sport readback", rd, d);
    end
    sport_read(8'h00, 0, rd);
    chk(rd == exp_mem[8'h00], "R6 sport no gap", rd, exp_mem[8'h00]);

    // R7 deselected traffic ignored
    w0 = we_cnt;
    cs_n = 1'b1; wait_n(H);
    sport_in(instr(1'b0, 8'h44), 0);
    sport_in(16'h0BAD, 0);
    wait_n(2 * H);
    chk(we_cnt == w0 && sdo_oe_o == 0, "R7 deselected sport", 32'(we_cnt - w0), 0);

    // back to chip-select framing, confirm bank content
    mode = 1'b0; wait_n(2 * H);
    spi_read(8'h44, rd);
    chk(rd == exp_mem[8'h44], "R7 register unchanged", rd, exp_mem[8'h44]);
    for (int k = 0; k < 4; k++) begin
      a = 8'($urandom);
      spi_read(a, rd);
      chk(rd == exp_mem[a], "R1 final sweep", rd, exp_mem[a]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule